// File: doc/BRIEF.md
# Nested Priority Exception Sequencer

This block decides when an exception request may interrupt the code that is running and carries out the entry and exit sequences around the handler. Requests arrive as set pulses on a per-number bus and are latched as pending. A priority table supplies a level for every exception number. The block compares the most urgent pending level with the current operating level. When the request wins, the block asks an external stack model to save the program counter. Only after that save completes does it raise privilege, adopt the new level and load the program counter from the vector table.

A return strobe starts the reverse sequence. The external stack model hands back the saved program counter. At the same time, the previous level and mode are taken from a small internal frame stack. Entries can nest up to a configurable depth, and they unwind in the reverse order of entry. A lower numeric level means a more urgent request. The thread level lies one step beyond the largest table value.

Top module: `nest_exc_seq`

## Requirements
- R1: After a synchronous reset the block is in the following state: `pc` = RESET_PC (0), `cur_lvl` = 8 (thread level), `priv_mode` = 1, no save or restore request active, and the frame stack empty.
- R2: A pending request is taken only when its table level is numerically lower than `cur_lvl`. A request with an equal or higher value stays pending and is considered again after each return.
- R3: When a request is taken, `ctx_push_req` rises while `pc`, `cur_lvl` and `priv_mode` keep their values, and `ctx_push_data` equals `pc`. These values do not change until `ctx_push_ack` is seen.
- R4: In the cycle after the push is acknowledged, `priv_mode` = 1, `cur_lvl` = the request's level and `pc` = `vec_data`. During the save, `vec_addr` = (16 + number) × 4, so number 22 reads byte address 152.
- R5: Among several pending requests, the one with the lowest level value is chosen. On a tie, the lowest exception number is chosen.
- R6: A return strobe with a non-empty frame stack raises `ctx_pop_req`. In the cycle after `ctx_pop_ack`, `pc` = `ctx_pop_data`, and `cur_lvl` and `priv_mode` return to their values from before the matching entry.
- R7: A more urgent request preempts a running handler. Nested entries unwind in reverse order.
- R8: When DEPTH (3) frames are held, no request is taken. The request stays pending and is taken once a return frees a frame.
- R9: An `irq_set` bit latches its request as pending, and an `irq_clr` bit removes it. If both arrive in the same cycle, the set wins. Taking a request clears its pending bit.
- R10: A return strobe with an empty frame stack is ignored: no `ctx_pop_req`, and no change to `pc`, `cur_lvl` or `priv_mode`.
- R11: If a return strobe and a takeable request meet in the same idle cycle, the return is performed first. The request is taken afterwards if it still beats the restored level.
- R12: A `drop_priv` pulse in the idle state clears `priv_mode` and leaves `cur_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | NUM_IRQ | Per-number request set pulses |
| irq_clr | input | NUM_IRQ | Per-number pending clear pulses |
| prio_tbl | input | NUM_IRQ*PRIO_W | Level of each exception number, number n at bits [n*PRIO_W +: PRIO_W] |
| ret_strobe | input | 1 | Handler return |
| drop_priv | input | 1 | Leave privileged mode while idle |
| vec_addr | output | ADDR_W | Vector table byte address of the selected number |
| vec_data | input | ADDR_W | Handler address read from the vector table |
| ctx_push_req | output | 1 | Context save request |
| ctx_push_data | output | ADDR_W | Program counter to save |
| ctx_push_ack | input | 1 | Context save done |
| ctx_pop_req | output | 1 | Context restore request |
| ctx_pop_data | input | ADDR_W | Restored program counter |
| ctx_pop_ack | input | 1 | Context restore done |
| pc | output | ADDR_W | Program counter |
| priv_mode | output | 1 | 1 = privileged |
| cur_lvl | output | PRIO_W+1 | Current operating level |

## Verification
A return strobe and a newly takeable request can fall in the same idle cycle. To provoke this, a handler is running, and a more urgent request's set pulse is timed so that its pending bit first becomes visible in exactly the cycle in which the return strobe is driven. The case is judged correct when the next cycle shows a restore request and no save request. The restored level must come back to thread level. Only after that may the request be taken, and the program counter it saves must be the restored thread value.

// File: rtl/nest_exc_pkg.sv
package nest_exc_pkg;

    // bits of a table level; the current level carries one bit more
    localparam int PRIO_W = 3;

    typedef logic [PRIO_W:0] lvl_t;

    // level of plain thread execution: below every table value
    localparam lvl_t THREAD_LVL = lvl_t'(1 << PRIO_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_RESTORE
    } seq_state_e;

    // what the internal stack keeps for each nesting level
    typedef struct packed {
        lvl_t lvl;
        logic priv;
    } frame_t;

    // byte address of the handler word for a given exception number
    function automatic logic [31:0] vec_byte_off(input int unsigned base,
                                                 input int unsigned num);
        return 32'((base + num) * 4);
    endfunction

endpackage

// File: rtl/nest_exc_pend.sv
module nest_exc_pend #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    input  logic [NUM_IRQ-1:0] taken_i,
    output logic [NUM_IRQ-1:0] pend_o
);

    // a set arriving in the same cycle as a clear or a take keeps the bit
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_i & ~taken_i) | set_i;
        end
    end

endmodule

// File: rtl/nest_exc_arb.sv
module nest_exc_arb
    import nest_exc_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int NUM_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_tbl_i,
    output logic                      any_o,
    output logic [NUM_W-1:0]          win_num_o,
    output lvl_t                      win_lvl_o
);

    // scan from the top number downward; "<=" lets a lower number take a tie
    always_comb begin
        any_o     = 1'b0;
        win_num_o = '0;
        win_lvl_o = THREAD_LVL;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend_i[i] && ({1'b0, prio_tbl_i[i*PRIO_W +: PRIO_W]} <= win_lvl_o)) begin
                any_o     = 1'b1;
                win_num_o = NUM_W'(i);
                win_lvl_o = {1'b0, prio_tbl_i[i*PRIO_W +: PRIO_W]};
            end
        end
    end

endmodule

// File: rtl/nest_exc_lifo.sv
module nest_exc_lifo
    import nest_exc_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  frame_t wdata_i,
    input  logic   pop_i,
    output frame_t top_o,
    output logic   full_o,
    output logic   empty_o
);

    frame_t           slot [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] top_idx;

    assign full_o  = (count == CNT_W'(DEPTH));
    assign empty_o = (count == '0);
    assign top_idx = count - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push_i && !pop_i) begin
            count <= count + 1'b1;
        end else if (pop_i && !push_i) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < DEPTH; g++) begin
            if (push_i && count == CNT_W'(g)) begin
                slot[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        top_o = '0;
        for (int g = 0; g < DEPTH; g++) begin
            if (!empty_o && top_idx == CNT_W'(g)) begin
                top_o = slot[g];
            end
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

endmodule

// File: rtl/nest_exc_seq.sv
module nest_exc_seq
    import nest_exc_pkg::*;
#(
    parameter int          NUM_IRQ  = 32,
    parameter int          DEPTH    = 3,
    parameter int          ADDR_W   = 32,
    parameter int unsigned VEC_BASE = 16,
    parameter int unsigned RESET_PC = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IRQ-1:0]        irq_set,
    input  logic [NUM_IRQ-1:0]        irq_clr,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_tbl,
    input  logic                      ret_strobe,
    input  logic                      drop_priv,
    output logic [ADDR_W-1:0]         vec_addr,
    input  logic [ADDR_W-1:0]         vec_data,
    output logic                      ctx_push_req,
    output logic [ADDR_W-1:0]         ctx_push_data,
    input  logic                      ctx_push_ack,
    output logic                      ctx_pop_req,
    input  logic [ADDR_W-1:0]         ctx_pop_data,
    input  logic                      ctx_pop_ack,
    output logic [ADDR_W-1:0]         pc,
    output logic                      priv_mode,
    output logic [PRIO_W:0]           cur_lvl
);

    localparam int NUM_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    seq_state_e         state;
    lvl_t               lvl_q;
    logic               priv_q;
    logic [ADDR_W-1:0]  pc_q;
    logic [NUM_W-1:0]   sel_num_q;
    lvl_t               sel_lvl_q;

    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] taken_mask;
    logic               any_pend;
    logic [NUM_W-1:0]   win_num;
    lvl_t               win_lvl;

    frame_t             top_frame;
    logic               lifo_full;
    logic               lifo_empty;

    logic               in_idle;
    logic               ret_go;
    logic               take_go;
    logic               save_done;
    logic               rest_done;

    nest_exc_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_i   (irq_set),
        .clr_i   (irq_clr),
        .taken_i (taken_mask),
        .pend_o  (pend)
    );

    nest_exc_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .pend_i     (pend),
        .prio_tbl_i (prio_tbl),
        .any_o      (any_pend),
        .win_num_o  (win_num),
        .win_lvl_o  (win_lvl)
    );

    nest_exc_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (save_done),
        .wdata_i ('{lvl: lvl_q, priv: priv_q}),
        .pop_i   (rest_done),
        .top_o   (top_frame),
        .full_o  (lifo_full),
        .empty_o (lifo_empty)
    );

    // return is served before a new entry when both are eligible
    assign in_idle   = (state == ST_IDLE);
    assign ret_go    = in_idle && ret_strobe && !lifo_empty;
    assign take_go   = in_idle && !ret_go && any_pend && !lifo_full && (win_lvl < lvl_q);
    assign save_done = (state == ST_SAVE) && ctx_push_ack;
    assign rest_done = (state == ST_RESTORE) && ctx_pop_ack;
    assign taken_mask = save_done ? (NUM_IRQ'(1) << sel_num_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lvl_q     <= THREAD_LVL;
            priv_q    <= 1'b1;
            pc_q      <= ADDR_W'(RESET_PC);
            sel_num_q <= '0;
            sel_lvl_q <= THREAD_LVL;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ret_go) begin
                        state <= ST_RESTORE;
                    end else if (take_go) begin
                        sel_num_q <= win_num;
                        sel_lvl_q <= win_lvl;
                        state     <= ST_SAVE;
                    end else if (drop_priv) begin
                        priv_q <= 1'b0;
                    end
                end
                ST_SAVE: begin
                    if (ctx_push_ack) begin
                        pc_q   <= vec_data;
                        lvl_q  <= sel_lvl_q;
                        priv_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_RESTORE: begin
                    if (ctx_pop_ack) begin
                        pc_q   <= ctx_pop_data;
                        lvl_q  <= top_frame.lvl;
                        priv_q <= top_frame.priv;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign vec_addr      = ADDR_W'(vec_byte_off(VEC_BASE, 32'(sel_num_q)));
    assign ctx_push_req  = (state == ST_SAVE);
    assign ctx_push_data = pc_q;
    assign ctx_pop_req   = (state == ST_RESTORE);
    assign pc            = pc_q;
    assign priv_mode     = priv_q;
    assign cur_lvl       = lvl_q;

    // R3
    save_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_push_req && !ctx_push_ack) |=> ($stable(pc) && $stable(cur_lvl) && $stable(priv_mode)));

    // R4
    entry_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_push_req && ctx_push_ack) |=> (priv_mode && cur_lvl < $past(cur_lvl)));

    // R6
    exit_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_pop_req && ctx_pop_ack) |=> (cur_lvl > $past(cur_lvl)));

    // R5
    win_pending_chk: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> pend[win_num]);

    // R11
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctx_push_req && ctx_pop_req));

endmodule

// File: tb/nest_exc_seq_test.sv
module nest_exc_seq_test;
    import nest_exc_pkg::*;

    localparam int N  = 32;
    localparam int D  = 3;
    localparam int AW = 32;
    localparam logic [31:0] HB = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]        irq_set = '0;
    logic [N-1:0]        irq_clr = '0;
    logic [N*PRIO_W-1:0] prio_tbl = '0;
    logic                ret_strobe = 1'b0;
    logic                drop_priv = 1'b0;
    logic [AW-1:0]       vec_addr;
    logic [AW-1:0]       vec_data;
    logic                ctx_push_req;
    logic [AW-1:0]       ctx_push_data;
    logic                ctx_push_ack = 1'b0;
    logic                ctx_pop_req;
    logic [AW-1:0]       ctx_pop_data = '0;
    logic                ctx_pop_ack = 1'b0;
    logic [AW-1:0]       pc;
    logic                priv_mode;
    logic [PRIO_W:0]     cur_lvl;

    // vector table model: handler word derived from its address
    assign vec_data = HB | vec_addr;

    nest_exc_seq #(.NUM_IRQ(N), .DEPTH(D), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .irq_set(irq_set), .irq_clr(irq_clr),
        .prio_tbl(prio_tbl), .ret_strobe(ret_strobe), .drop_priv(drop_priv),
        .vec_addr(vec_addr), .vec_data(vec_data),
        .ctx_push_req(ctx_push_req), .ctx_push_data(ctx_push_data), .ctx_push_ack(ctx_push_ack),
        .ctx_pop_req(ctx_pop_req), .ctx_pop_data(ctx_pop_data), .ctx_pop_ack(ctx_pop_ack),
        .pc(pc), .priv_mode(priv_mode), .cur_lvl(cur_lvl)
    );

    int n_chk = 0;
    int n_bad = 0;

    // expected architectural state and stack model
    logic [31:0] exp_pc   = 32'h0;
    logic [31:0] exp_lvl  = 32'd8;
    logic        exp_priv = 1'b1;
    logic [31:0] m_pc   [8];
    logic [31:0] m_lvl  [8];
    logic        m_priv [8];
    int          sp = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_prio(input int n, input int p);
        prio_tbl[n*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    task automatic raise(input int n);
        irq_set[n] = 1'b1;
        tick();
        irq_set[n] = 1'b0;
    endtask

    task automatic chk_state(input string req);
        chk(req, "pc", pc, exp_pc);
        chk(req, "cur_lvl", 32'(cur_lvl), exp_lvl);
        chk(req, "priv_mode", 32'(priv_mode), 32'(exp_priv));
    endtask

    task automatic quiet(input string req, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (ctx_push_req || ctx_pop_req) seen = 1'b1;
        end
        chk(req, "no save/restore request", 32'(seen), 32'(0));
        chk_state(req);
    endtask

    task automatic serve_push(input string req, input int n, input int p);
        for (int i = 0; i < 20 && !ctx_push_req; i++) tick();
        chk(req, "save request", 32'(ctx_push_req), 32'(1));
        chk("R4", "vec_addr", vec_addr, 32'((16 + n) * 4));
        chk("R3", "push data", ctx_push_data, exp_pc);
        chk_state("R3");
        tick();
        chk_state("R3");
        ctx_push_ack = 1'b1;
        m_pc[sp]   = exp_pc;
        m_lvl[sp]  = exp_lvl;
        m_priv[sp] = exp_priv;
        sp++;
        tick();
        ctx_push_ack = 1'b0;
        exp_pc   = HB | 32'((16 + n) * 4);
        exp_lvl  = 32'(p);
        exp_priv = 1'b1;
        chk_state(req);
    endtask

    task automatic serve_pop(input string req);
        for (int i = 0; i < 20 && !ctx_pop_req; i++) tick();
        chk(req, "restore request", 32'(ctx_pop_req), 32'(1));
        sp--;
        ctx_pop_data = m_pc[sp];
        ctx_pop_ack  = 1'b1;
        tick();
        ctx_pop_ack = 1'b0;
        exp_pc   = m_pc[sp];
        exp_lvl  = m_lvl[sp];
        exp_priv = m_priv[sp];
        chk_state(req);
    endtask

    task automatic do_return(input string req);
        ret_strobe = 1'b1;
        tick();
        ret_strobe = 1'b0;
        serve_pop(req);
    endtask

    task automatic t_reset();
        chk_state("R1");
        chk("R1", "push req", 32'(ctx_push_req), 32'(0));
        chk("R1", "pop req", 32'(ctx_pop_req), 32'(0));
    endtask

    task automatic t_basic();
        set_prio(22, 3);
        raise(22);
        serve_push("R4", 22, 3);
        do_return("R6");
        quiet("R9", 5);
    endtask

    task automatic t_nest();
        set_prio(5, 2); set_prio(6, 2); set_prio(7, 1);
        raise(5);
        serve_push("R2", 5, 2);
        raise(6);
        quiet("R2", 5);
        raise(7);
        serve_push("R7", 7, 1);
        do_return("R7");
        quiet("R2", 4);
        do_return("R7");
        serve_push("R2", 6, 2);
        do_return("R6");
    endtask

    task automatic t_select();
        set_prio(3, 4); set_prio(9, 1); set_prio(12, 1);
        irq_set[3] = 1'b1; irq_set[9] = 1'b1; irq_set[12] = 1'b1;
        tick();
        irq_set = '0;
        serve_push("R5", 9, 1);
        do_return("R5");
        serve_push("R5", 12, 1);
        do_return("R5");
        serve_push("R5", 3, 4);
        do_return("R5");
    endtask

    task automatic t_overflow();
        set_prio(1, 6); set_prio(2, 5); set_prio(3, 4); set_prio(4, 0);
        raise(1); serve_push("R7", 1, 6);
        raise(2); serve_push("R7", 2, 5);
        raise(3); serve_push("R7", 3, 4);
        raise(4);
        quiet("R8", 6);
        do_return("R8");
        serve_push("R8", 4, 0);
        do_return("R8");
        do_return("R8");
        do_return("R8");
        chk("R8", "final level", 32'(cur_lvl), 32'd8);
    endtask

    task automatic t_pend();
        set_prio(0, 0); set_prio(8, 3); set_prio(11, 3);
        raise(0);
        serve_push("R9", 0, 0);
        irq_set[11] = 1'b1; irq_clr[11] = 1'b1;
        tick();
        irq_set = '0; irq_clr = '0;
        raise(8);
        irq_clr[8] = 1'b1;
        tick();
        irq_clr = '0;
        do_return("R9");
        serve_push("R9", 11, 3);
        do_return("R9");
        quiet("R9", 5);
    endtask

    task automatic t_empty_ret();
        ret_strobe = 1'b1;
        tick();
        ret_strobe = 1'b0;
        chk("R10", "pop req", 32'(ctx_pop_req), 32'(0));
        quiet("R10", 4);
    endtask

    task automatic t_same_cycle();
        set_prio(5, 2); set_prio(7, 1);
        raise(5);
        serve_push("R11", 5, 2);
        irq_set[7] = 1'b1;
        tick();
        irq_set[7] = 1'b0;
        ret_strobe = 1'b1;
        tick();
        ret_strobe = 1'b0;
        chk("R11", "restore first", 32'(ctx_pop_req), 32'(1));
        chk("R11", "no save yet", 32'(ctx_push_req), 32'(0));
        serve_pop("R11");
        serve_push("R11", 7, 1);
        do_return("R11");
    endtask

    task automatic t_drop();
        set_prio(2, 3);
        drop_priv = 1'b1;
        tick();
        drop_priv = 1'b0;
        exp_priv = 1'b0;
        chk_state("R12");
        raise(2);
        serve_push("R12", 2, 3);
        do_return("R6");
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_nest();
        t_select();
        t_overflow();
        t_pend();
        t_empty_ret();
        t_same_cycle();
        t_drop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule